// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Target

This block is the target side of a two-wire serial bus (I2C) for a device whose settings live in a byte-addressed register file. Both bus lines are oversampled by the system clock, which must run at least sixteen times faster than SCL. A 400 kHz bus therefore needs a system clock of 6.4 MHz or more. After synchronization, the block detects START and STOP conditions and SCL edges and runs a small bit-level engine. The engine receives the header byte, compares its upper seven bits with its own address, acknowledges a match and then moves data bytes. The direction follows the lowest header bit.

The block picks its own address once after reset by reading a configuration strap. The strap must show the same level on four consecutive clock edges; any change restarts the count. Until the address is latched, the target neither acknowledges nor drives SDA. An input from the device's boot logic keeps the target quiet while a separate boot master owns the bus. The target comes back when that input drops.

Register access uses a plain strobe port. In a write transfer, the first data byte sets an internal pointer and each later byte produces a one-cycle write strobe at the pointer, which then advances. In a read transfer, each byte is fetched through a one-cycle read strobe at the pointer, with the read data taken combinationally, and the pointer then advances.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, the strap is sampled on every clock edge. The address is latched only when four consecutive samples agree, and any disagreement restarts the count from the disagreeing sample. Once latched, the address never changes until the next reset.
- R2: A strap latched low gives the 7-bit address 0x1A (header bytes 0x34 write, 0x35 read). A strap latched high gives 0x1B (0x36 write, 0x37 read). Only the latched address is acknowledged.
- R3: A START (SDA falling while SCL is high) sends the target to header reception from any state, including in the middle of a byte. The register pointer is kept across a repeated START.
- R4: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. Bits clocked after a STOP and without a new START are not acknowledged and cause no register access.
- R5: The header byte is shifted in MSB first on SCL rising edges. On a match, the target pulls SDA low for the whole ninth SCL pulse. On a mismatch, it leaves SDA released and ignores the bus until the next START.
- R6: With header bit 0 at 0, every data byte is acknowledged. The first byte loads the pointer. Each later byte gives one reg_wr_o pulse with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte, and the pointer then increments.
- R7: With header bit 0 at 1, after the header acknowledge and after each controller ACK, the target gives one reg_rd_o pulse at the pointer, shifts out reg_rdata_i MSB first, and increments the pointer.
- R8: After a controller NACK of a read byte, the target releases SDA and makes no further read strobes until the next START.
- R9: While boot_busy_i is high, the target ignores all bus activity and never drives SDA. It responds normally once boot_busy_i is low.
- R10: Before the address is latched, the target never drives SDA and makes no register access.
- R11: reg_wr_o and reg_rd_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Address strap level, sampled after reset |
| boot_busy_i | input | 1 | High while a boot master owns the bus |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain enable) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 8 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, combinational |

## Verification
The bound checker watches these properties on every cycle:
- SDA is never driven before the address is latched or while boot is held.
- The latched address stays stable.
- A START always lands the engine in header reception.
- SDA is free after a STOP.
- The two register strobes never overlap.

Other behaviour is only visible across whole transfers, so the bench scenarios cover it: which strap pattern yields which address, byte order, pointer loading and auto-increment, controller ACK/NACK handling, mismatched headers, and restarts in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_BITS = 8;

  typedef struct packed {
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;

  // Address chosen by the latched strap level.
  function automatic logic [6:0] strap_addr(input logic [6:0] lo_addr,
                                            input logic [6:0] hi_addr,
                                            input logic       sel);
    return sel ? hi_addr : lo_addr;
  endfunction

  // Header byte matches own 7-bit address (upper seven bits).
  function automatic logic header_hit(input logic [7:0] hdr, input logic [6:0] own);
    return hdr[7:1] == own;
  endfunction

  // MSB-first shift of one received bit.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
  import i2c_tgt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);

  localparam int DEPTH = STAGES + 1;
  localparam int NOW   = STAGES - 1;
  localparam int PREV  = STAGES;

  logic [DEPTH-1:0] scl_pipe;
  logic [DEPTH-1:0] sda_pipe;

  // Bus idles high, so the pipes reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_pipe[NOW];
  assign scl_prev = scl_pipe[PREV];
  assign sda_now  = sda_pipe[NOW];
  assign sda_prev = sda_pipe[PREV];

  assign evt.sda      = sda_now;
  assign evt.scl_rise = scl_now & ~scl_prev;
  assign evt.scl_fall = ~scl_now & scl_prev;
  assign evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_tgt_strap.sv
module i2c_tgt_strap #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic locked,
  output logic strap_sel
);

  localparam int CW = $clog2(SAMPLES + 1);

  logic [CW-1:0] agree_cnt;
  logic          sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agree_cnt <= '0;
      sample_q  <= 1'b0;
      locked    <= 1'b0;
      strap_sel <= 1'b0;
    end else if (!locked) begin
      if (agree_cnt == '0 || strap_i != sample_q) begin
        sample_q  <= strap_i;
        agree_cnt <= CW'(1);
      end else if (agree_cnt == CW'(SAMPLES - 1)) begin
        locked    <= 1'b1;
        strap_sel <= sample_q;
      end else begin
        agree_cnt <= agree_cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  bus_evt_t      evt,
  input  logic [6:0]    own_addr,
  output logic          sda_oe,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          in_addr
);

  localparam int BCW = $clog2(BYTE_BITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_BITS);

  tgt_state_e    state_q;
  logic [BCW-1:0] bitcnt_q;
  logic [7:0]    shreg_q;
  logic [7:0]    tx_q;
  logic [AW-1:0] ptr_q;
  logic          first_q;
  logic          rw_q;
  logic          mack_q;
  logic          oe_q;

  logic byte_done;
  assign byte_done = evt.scl_fall && bitcnt_q == LAST_BIT;

  assign reg_wr = en && state_q == ST_WR_BYTE && byte_done && !first_q;
  assign reg_rd = en && evt.scl_fall &&
                  ((state_q == ST_ADDR_ACK && rw_q) || (state_q == ST_RD_ACK && mack_q));
  assign reg_addr  = ptr_q;
  assign reg_wdata = shreg_q;
  assign sda_oe    = oe_q;
  assign in_addr   = state_q == ST_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      first_q  <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (!en) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (evt.start) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      first_q  <= 1'b1;
      oe_q     <= 1'b0;
    end else if (evt.stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: oe_q <= 1'b0;

        ST_ADDR: begin
          if (evt.scl_rise) begin
            shreg_q  <= shift_in(shreg_q, evt.sda);
            bitcnt_q <= bitcnt_q + BCW'(1);
          end else if (byte_done) begin
            if (header_hit(shreg_q, own_addr)) begin
              rw_q    <= shreg_q[0];
              oe_q    <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (evt.scl_fall) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              tx_q    <= reg_rdata;
              oe_q    <= ~reg_rdata[7];
              ptr_q   <= ptr_q + AW'(1);
              state_q <= ST_RD_BYTE;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR_BYTE;
            end
          end
        end

        ST_WR_BYTE: begin
          if (evt.scl_rise) begin
            shreg_q  <= shift_in(shreg_q, evt.sda);
            bitcnt_q <= bitcnt_q + BCW'(1);
          end else if (byte_done) begin
            oe_q    <= 1'b1;
            state_q <= ST_WR_ACK;
            first_q <= 1'b0;
            if (first_q) ptr_q <= AW'(shreg_q);
            else         ptr_q <= ptr_q + AW'(1);
          end
        end

        ST_WR_ACK: begin
          if (evt.scl_fall) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ST_WR_BYTE;
          end
        end

        ST_RD_BYTE: begin
          if (evt.scl_rise) begin
            bitcnt_q <= bitcnt_q + BCW'(1);
          end else if (byte_done) begin
            oe_q    <= 1'b0;
            state_q <= ST_RD_ACK;
          end else if (evt.scl_fall) begin
            tx_q <= {tx_q[6:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end

        ST_RD_ACK: begin
          if (evt.scl_rise) begin
            mack_q <= ~evt.sda;
          end else if (evt.scl_fall) begin
            if (mack_q) begin
              bitcnt_q <= '0;
              tx_q     <= reg_rdata;
              oe_q     <= ~reg_rdata[7];
              ptr_q    <= ptr_q + AW'(1);
              state_q  <= ST_RD_BYTE;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int         SYNC_STAGES  = 2,
  parameter int         STRAP_AGREE  = 4,
  parameter int         AW           = 8,
  parameter logic [6:0] ADDR_STRAP_LO = 7'h1A,
  parameter logic [6:0] ADDR_STRAP_HI = 7'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_i,
  input  logic          boot_busy_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          reg_wr_o,
  output logic          reg_rd_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);

  bus_evt_t   evt;
  logic       addr_locked;
  logic       strap_sel;
  logic [6:0] own_addr;
  logic       tgt_en;
  logic       hdr_phase;
  logic       start_evt;
  logic       stop_evt;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  i2c_tgt_strap #(.SAMPLES(STRAP_AGREE)) strap_i0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_i),
    .locked    (addr_locked),
    .strap_sel (strap_sel)
  );

  assign own_addr  = strap_addr(ADDR_STRAP_LO, ADDR_STRAP_HI, strap_sel);
  assign tgt_en    = addr_locked & ~boot_busy_i;
  assign start_evt = evt.start;
  assign stop_evt  = evt.stop;

  i2c_tgt_engine #(.AW(AW)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tgt_en),
    .evt       (evt),
    .own_addr  (own_addr),
    .sda_oe    (sda_oe_o),
    .reg_wr    (reg_wr_o),
    .reg_rd    (reg_rd_o),
    .reg_addr  (reg_addr_o),
    .reg_wdata (reg_wdata_o),
    .reg_rdata (reg_rdata_i),
    .in_addr   (hdr_phase)
  );

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       locked,
  input logic [6:0] own_addr,
  input logic       boot_busy,
  input logic       en,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       hdr_phase
);

  // R10
  no_drive_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sda_oe && !reg_wr && !reg_rd);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(own_addr));

  // R9
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |=> !sda_oe);

  // R9
  boot_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |-> !reg_wr && !reg_rd);

  // R3
  start_to_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && en |=> hdr_phase);

  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

endmodule

bind i2c_strap_target i2c_strap_target_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .locked    (addr_locked),
  .own_addr  (own_addr),
  .boot_busy (boot_busy_i),
  .en        (tgt_en),
  .sda_oe    (sda_oe_o),
  .reg_wr    (reg_wr_o),
  .reg_rd    (reg_rd_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .hdr_phase (hdr_phase)
);

// File: tb/i2c_strap_target_tb_top.sv
module i2c_strap_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;   // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_i = 1'b0;
  logic       strap_toggle = 1'b0;
  logic       boot_busy_i = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe_o, reg_wr_o, reg_rd_o;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
  logic       sda_bus;

  logic [7:0] mem [256];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  int         boot_drive = 0;
  int         tests_run = 0;
  int         tests_failed = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus     = sda_m & ~sda_oe_o;
  assign reg_rdata_i = mem[reg_addr_o];

  i2c_strap_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .boot_busy_i (boot_busy_i),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
  );

  always @(posedge clk) begin
    if (reg_wr_o) begin
      mem[reg_addr_o] <= reg_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd_o) rd_cnt <= rd_cnt + 1;
    if (boot_busy_i && sda_oe_o) boot_drive <= boot_drive + 1;
  end

  always @(negedge clk) if (strap_toggle) strap_i <= ~strap_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_bus; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!give_ack);
  endtask

  task automatic do_reset(input logic s);
    strap_toggle = 1'b0;
    strap_i = s;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R10: quiet outputs in reset and right after it
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!sda_oe_o && !reg_wr_o && !reg_rd_o, "R10 reset outputs",
          {sda_oe_o, reg_wr_o, reg_rd_o}, 0);
    do_reset(1'b0);
    check(!sda_oe_o, "R10 after reset", sda_oe_o, 0);
  endtask

  // R1 R2 R10: unstable strap blocks response, high strap gives 0x1B
  task automatic t_strap_unstable();
    bit ack;
    int w0;
    strap_i = 1'b0;
    rst_n = 1'b0;
    strap_toggle = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    w0 = wr_cnt;
    bus_start(); send_byte(8'h34, ack);
    check(!ack, "R10 unlocked no ack 0x34", ack, 0);
    send_byte(8'h05, ack); send_byte(8'h5A, ack);
    bus_stop();
    bus_start(); send_byte(8'h36, ack);
    check(!ack, "R1 unlocked no ack 0x36", ack, 0);
    bus_stop();
    check(wr_cnt == w0, "R10 no access while unlocked", wr_cnt - w0, 0);
    strap_toggle = 1'b0;
    @(negedge clk) strap_i = 1'b1;
    repeat (10) @(negedge clk);
    bus_start(); send_byte(8'h34, ack);
    check(!ack, "R2 high strap ignores 0x34", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'h36, ack);
    check(ack, "R2 high strap acks 0x36", ack, 1);
    bus_stop();
  endtask

  // R1: three high samples then low must latch low address
  task automatic t_strap_glitch();
    bit ack;
    strap_toggle = 1'b0;
    strap_i = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) strap_i = 1'b0;
    repeat (10) @(negedge clk);
    bus_start(); send_byte(8'h36, ack);
    check(!ack, "R1 restarted count rejects 0x36", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'h34, ack);
    check(ack, "R1 restarted count acks 0x34", ack, 1);
    bus_stop();
  endtask

  // R5 R6: pointer then burst of writes
  task automatic t_write_burst();
    bit a0, a1, a2, a3, a4;
    int w0;
    mem[8'h13] = 8'h00;
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h10, a1);
    send_byte(8'hA5, a2);
    send_byte(8'h3C, a3);
    send_byte(8'hFF, a4);
    bus_stop();
    check(a0, "R5 header ack", a0, 1);
    check(a1 && a2 && a3 && a4, "R6 data acks", {a1, a2, a3, a4}, 4'hF);
    check(mem[8'h10] == 8'hA5, "R6 mem[10]", mem[8'h10], 8'hA5);
    check(mem[8'h11] == 8'h3C, "R6 mem[11]", mem[8'h11], 8'h3C);
    check(mem[8'h12] == 8'hFF, "R6 mem[12]", mem[8'h12], 8'hFF);
    check(mem[8'h13] == 8'h00, "R6 mem[13] untouched", mem[8'h13], 0);
    check(wr_cnt - w0 == 3, "R6 write strobes", wr_cnt - w0, 3);
  endtask

  // R3 R7 R8: pointer set, repeated START, read burst, NACK
  task automatic t_read_burst();
    bit ack;
    logic [7:0] d0, d1, d2, d3;
    int r0;
    mem[8'h20] = 8'h81; mem[8'h21] = 8'h5A; mem[8'h22] = 8'hC3; mem[8'h23] = 8'h00;
    bus_start();
    send_byte(8'h34, ack);
    send_byte(8'h20, ack);
    r0 = rd_cnt;
    bus_start();
    send_byte(8'h35, ack);
    check(ack, "R3 ack after repeated start", ack, 1);
    recv_byte(1'b1, d0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    check(d0 == 8'h81, "R7 byte0", d0, 8'h81);
    check(d1 == 8'h5A, "R7 byte1", d1, 8'h5A);
    check(d2 == 8'hC3, "R7 byte2", d2, 8'hC3);
    check(rd_cnt - r0 == 3, "R7 read strobes", rd_cnt - r0, 3);
    recv_byte(1'b0, d3);
    check(d3 == 8'hFF, "R8 released after nack", d3, 8'hFF);
    check(rd_cnt - r0 == 3, "R8 no read after nack", rd_cnt - r0, 3);
    bus_stop();
  endtask

  // R5: foreign header ignored
  task automatic t_mismatch();
    bit a0, a1;
    int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h3C, a0);
    send_byte(8'h00, a1);
    bus_stop();
    check(!a0, "R5 mismatch header nack", a0, 0);
    check(!a1, "R5 mismatch data nack", a1, 0);
    check(wr_cnt == w0, "R5 no writes on mismatch", wr_cnt - w0, 0);
  endtask

  // R4: STOP ends transfer, bare bits ignored
  task automatic t_stop();
    bit ack;
    int w0;
    bus_start();
    send_byte(8'h34, ack);
    send_byte(8'h50, ack);
    send_byte(8'h11, ack);
    bus_stop();
    repeat (4) @(negedge clk);
    check(!sda_oe_o, "R4 sda released after stop", sda_oe_o, 0);
    check(mem[8'h50] == 8'h11, "R4 write before stop", mem[8'h50], 8'h11);
    w0 = wr_cnt;
    scl_m = 1'b0; wait_q();
    send_byte(8'h34, ack);
    check(!ack, "R4 no ack without start", ack, 0);
    send_byte(8'h22, ack);
    bus_stop();
    check(wr_cnt == w0, "R4 no write without start", wr_cnt - w0, 0);
  endtask

  // R3: START in the middle of a byte restarts header reception
  task automatic t_restart_midbyte();
    bit a0, a1, a2;
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h40, a1);
    send_byte(8'h77, a2);
    bus_stop();
    check(a0 && a1 && a2, "R3 mid-byte restart acks", {a0, a1, a2}, 3'b111);
    check(mem[8'h40] == 8'h77, "R3 write after restart", mem[8'h40], 8'h77);
  endtask

  // R9: boot phase silences the target
  task automatic t_boot();
    bit a0, a1;
    int w0;
    mem[8'h60] = 8'h00;
    w0 = wr_cnt;
    @(negedge clk) boot_busy_i = 1'b1;
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h60, a1);
    send_byte(8'h99, a1);
    bus_stop();
    check(!a0, "R9 no ack during boot", a0, 0);
    check(wr_cnt == w0, "R9 no write during boot", wr_cnt - w0, 0);
    check(boot_drive == 0, "R9 sda never driven during boot", boot_drive, 0);
    @(negedge clk) boot_busy_i = 1'b0;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h60, a1);
    send_byte(8'h99, a1);
    bus_stop();
    check(a0, "R9 ack after boot", a0, 1);
    check(mem[8'h60] == 8'h99, "R9 write after boot", mem[8'h60], 8'h99);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_strap_unstable();
    t_strap_glitch();
    t_write_burst();
    t_read_burst();
    t_mismatch();
    t_stop();
    t_restart_midbyte();
    t_boot();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule